// File: doc/BRIEF.md
# USB Dual-Role Port Role Controller

This block decides, once per clock, whether a dual-role USB port behaves as the host-side device that supplies bus power or as the peripheral-side device that draws it. It watches sampled levels from the bus detection logic: the identification pin, the two supply-valid comparators, the peripheral session-valid comparator and a peer-absent indication from the host stack. It also takes single-cycle software pulses that request the bus, drop the bus or clear a supply fault. From these it steps a nine-state role machine and drives the supply enable, the host-stack enable, the peripheral-stack enable and a flag saying which side of the cable the port sits on.

When the port becomes the host side and the supply has risen, the controller marks the peer as connected on its own, so it moves straight on to hosting. If the host stack reports the peer as absent, the controller waits a bounded number of external 10 ms ticks for it; when that wait runs out, it removes the supply.

Top module: `otg_role_ctrl`

## Requirements
- R1: While `rst` is high, `role_state` is 0 and every output is low. The first clock after reset treats state 0 exactly like DEV_IDLE, so with `id_pin` low it lands directly in HOST_IDLE.
- R2: `role_state` encodings: 0 reset, 1 DEV_IDLE, 2 DEV_ACTIVE, 3 HOST_IDLE, 4 VBUS_RAMP, 5 AWAIT_PEER, 6 HOSTING, 7 VBUS_DRAIN, 8 VBUS_FAULT.
- R3: At most one state change per clock. A condition that calls for further changes is re-evaluated on the following clocks.
- R4: DEV_IDLE goes to HOST_IDLE when `id_pin` is 0. Failing that, it goes to DEV_ACTIVE when `b_sess_vld` is 1. DEV_ACTIVE returns to DEV_IDLE when `b_sess_vld` is 0 or `id_pin` is 0. `periph_en` rises on entry to DEV_ACTIVE and falls on its exit.
- R5: HOST_IDLE goes to DEV_IDLE when `id_pin` is 1. Failing that, it goes to VBUS_RAMP when no bus drop is latched and either a bus request is latched or `srp_det` is 1. `vbus_drive` rises on entry to VBUS_RAMP.
- R6: VBUS_RAMP goes to AWAIT_PEER once `a_vbus_vld` is 1. Entry to AWAIT_PEER sets the internal connect flag, and it raises `host_en` unless the previous state was HOSTING. The effective connect is that flag AND NOT `peer_absent`.
- R7: AWAIT_PEER exits in this priority order. First, `id_pin` 1, a latched bus drop or a timeout send it to VBUS_DRAIN and clear the latched bus request. Second, `a_vbus_vld` 0 sends it to VBUS_FAULT. Third, effective connect sends it to HOSTING.
- R8: The wait counter starts from zero on every entry to AWAIT_PEER and counts only clocks on which `tick_10ms` is high. A timeout is seen on the evaluation after the BCON_TICKS-th counted tick (default 2000).
- R9: HOSTING returns to AWAIT_PEER on `id_pin` 1, loss of effective connect, or a latched bus drop. Failing those, `a_vbus_vld` 0 sends it to VBUS_FAULT.
- R10: Entry to VBUS_DRAIN lowers `vbus_drive` and clears the connect flag. VBUS_DRAIN goes to HOST_IDLE on `id_pin` 1, a latched bus request, or `a_sess_vld` 1 with no effective connect. `host_en` falls on that entry.
- R11: VBUS_FAULT leaves `vbus_drive` unchanged. It goes to VBUS_DRAIN on `id_pin` 1, a latched clear-error or a latched bus drop, and the latched clear-error is consumed on that exit.
- R12: The software pulses `sw_bus_req`, `sw_bus_drop` and `sw_clr_err` are latched one clock before the state machine acts on them. A drop pulse clears the bus request and a request pulse clears the drop. A drop wins if both arrive together, and a new pulse wins over a state-machine clear in the same clock.
- R13: `default_a` clears on entry to DEV_IDLE and sets on entry to HOST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_10ms | input | 1 | One-clock pulse every 10 ms, advances the wait counter |
| id_pin | input | 1 | Identification level, 0 = host side cable end |
| a_vbus_vld | input | 1 | Supply at valid host-side level |
| a_sess_vld | input | 1 | Supply above host-side session threshold |
| b_sess_vld | input | 1 | Supply above peripheral-side session threshold |
| srp_det | input | 1 | Peer asked for a session |
| peer_absent | input | 1 | Host stack reports no attached peer |
| sw_bus_req | input | 1 | Software pulse: request the bus |
| sw_bus_drop | input | 1 | Software pulse: drop the bus |
| sw_clr_err | input | 1 | Software pulse: clear supply fault |
| role_state | output | 4 | Current state code (R2) |
| vbus_drive | output | 1 | Supply driver enable |
| host_en | output | 1 | Host stack enable |
| periph_en | output | 1 | Peripheral stack enable |
| default_a | output | 1 | Port is on the host side of the cable |

## Verification
The bench applies the identification change and the supply loss in the same clock while the controller waits for its peer. A design with the exit priority swapped would land in the fault state instead of draining the supply. It holds the tick low for a while inside the wait state and then counts exactly the timeout length. An off-by-one counter, or one that runs on every clock, would leave a cycle early, and one that never finishes would keep the supply on. It also checks that a consumed clear-error does not release a later fault, and that a drop pulse arriving together with a request keeps the port idle. It steps the reset-state shortcut and the one-change-per-clock rule edge by edge; a design that chained two changes in one clock would skip the intermediate states these checks expect.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

    typedef enum logic [3:0] {
        ST_RESET      = 4'd0,
        ST_DEV_IDLE   = 4'd1,
        ST_DEV_ACTIVE = 4'd2,
        ST_HOST_IDLE  = 4'd3,
        ST_VBUS_RAMP  = 4'd4,
        ST_AWAIT_PEER = 4'd5,
        ST_HOSTING    = 4'd6,
        ST_VBUS_DRAIN = 4'd7,
        ST_VBUS_FAULT = 4'd8
    } role_state_e;

    typedef struct packed {
        logic id;
        logic a_vbus_vld;
        logic a_sess_vld;
        logic b_sess_vld;
        logic srp_det;
        logic connect;
        logic bus_req;
        logic bus_drop;
        logic clr_err;
        logic timeout;
    } role_in_t;

    // One evaluation step of the role machine; the reset code acts as peripheral idle.
    function automatic role_state_e role_next(role_state_e cur, role_in_t s);
        role_state_e n;
        n = cur;
        case (cur)
            ST_RESET, ST_DEV_IDLE: begin
                if (!s.id)              n = ST_HOST_IDLE;
                else if (s.b_sess_vld)  n = ST_DEV_ACTIVE;
                else                    n = ST_DEV_IDLE;
            end
            ST_DEV_ACTIVE:
                if (!s.b_sess_vld || !s.id) n = ST_DEV_IDLE;
            ST_HOST_IDLE: begin
                if (s.id)                                        n = ST_DEV_IDLE;
                else if (!s.bus_drop && (s.bus_req || s.srp_det)) n = ST_VBUS_RAMP;
            end
            ST_VBUS_RAMP:
                if (s.a_vbus_vld) n = ST_AWAIT_PEER;
            ST_AWAIT_PEER: begin
                if (s.id || s.bus_drop || s.timeout) n = ST_VBUS_DRAIN;
                else if (!s.a_vbus_vld)              n = ST_VBUS_FAULT;
                else if (s.connect)                  n = ST_HOSTING;
            end
            ST_HOSTING: begin
                if (s.id || !s.connect || s.bus_drop) n = ST_AWAIT_PEER;
                else if (!s.a_vbus_vld)               n = ST_VBUS_FAULT;
            end
            ST_VBUS_DRAIN:
                if (s.id || s.bus_req || (!s.connect && s.a_sess_vld)) n = ST_HOST_IDLE;
            ST_VBUS_FAULT:
                if (s.id || s.clr_err || s.bus_drop) n = ST_VBUS_DRAIN;
            default: n = ST_DEV_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/otg_req_latch.sv
module otg_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic sw_bus_req,
    input  logic sw_bus_drop,
    input  logic sw_clr_err,
    input  logic fsm_req_clr,
    input  logic fsm_err_take,
    output logic bus_req,
    output logic bus_drop,
    output logic clr_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req  <= 1'b0;
            bus_drop <= 1'b0;
            clr_err  <= 1'b0;
        end else begin
            if (sw_bus_drop) begin
                bus_drop <= 1'b1;
                bus_req  <= 1'b0;
            end else if (sw_bus_req) begin
                bus_req  <= 1'b1;
                bus_drop <= 1'b0;
            end else if (fsm_req_clr) begin
                bus_req  <= 1'b0;
            end

            if (sw_clr_err)        clr_err <= 1'b1;
            else if (fsm_err_take) clr_err <= 1'b0;
        end
    end

    AST_REQ_DROP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_drop)); // R12

    AST_DROP_BEATS_REQ: assert property (@(posedge clk) disable iff (rst)
        sw_bus_drop |=> (bus_drop && !bus_req)); // R12
endmodule

// File: rtl/otg_wait_timer.sv
module otg_wait_timer #(
    parameter int BCON_TICKS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(BCON_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(BCON_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)              cnt <= '0;
        else if (tick && (cnt != LIM))   cnt <= cnt + 1'b1;
    end

    assign expired = active && (cnt == LIM);

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> !expired); // R8
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
    import otg_role_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  role_in_t    sig,
    output role_state_e state_q,
    output logic        vbus_drive,
    output logic        host_en,
    output logic        periph_en,
    output logic        default_a,
    output logic        conn_flag,
    output logic        req_clr,
    output logic        err_take
);
    role_state_e nxt;
    logic        moving;

    always_comb begin
        nxt      = role_next(state_q, sig);
        moving   = (nxt != state_q);
        req_clr  = (state_q == ST_AWAIT_PEER) && (nxt == ST_VBUS_DRAIN);
        err_take = (state_q == ST_VBUS_FAULT) && (nxt == ST_VBUS_DRAIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RESET;
            vbus_drive <= 1'b0;
            host_en    <= 1'b0;
            periph_en  <= 1'b0;
            default_a  <= 1'b0;
            conn_flag  <= 1'b0;
        end else begin
            state_q <= nxt;
            if (moving) begin
                case (nxt)
                    ST_DEV_IDLE: begin
                        default_a <= 1'b0;
                        if (state_q == ST_DEV_ACTIVE) periph_en <= 1'b0;
                    end
                    ST_DEV_ACTIVE: periph_en <= 1'b1;
                    ST_HOST_IDLE: begin
                        default_a <= 1'b1;
                        if (state_q == ST_VBUS_DRAIN) host_en <= 1'b0;
                    end
                    ST_VBUS_RAMP: vbus_drive <= 1'b1;
                    ST_AWAIT_PEER: begin
                        conn_flag <= 1'b1;
                        if (state_q != ST_HOSTING) host_en <= 1'b1;
                    end
                    ST_VBUS_DRAIN: begin
                        conn_flag  <= 1'b0;
                        vbus_drive <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_RESET_LEAVE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESET) |=> (state_q != ST_RESET)); // R1
    AST_PERIPH_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        periph_en |-> (state_q == ST_DEV_ACTIVE)); // R4
    AST_VBUS_ON_RAMP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VBUS_RAMP) |-> vbus_drive); // R5
    AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_AWAIT_PEER && sig.timeout) |=> (state_q == ST_VBUS_DRAIN)); // R7
    AST_VBUS_OFF_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VBUS_DRAIN) |-> !vbus_drive); // R10
    AST_DEV_SIDE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEV_IDLE || state_q == ST_DEV_ACTIVE) |-> !default_a); // R13
endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
    import otg_role_pkg::*;
#(
    parameter int BCON_TICKS = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_10ms,
    input  logic       id_pin,
    input  logic       a_vbus_vld,
    input  logic       a_sess_vld,
    input  logic       b_sess_vld,
    input  logic       srp_det,
    input  logic       peer_absent,
    input  logic       sw_bus_req,
    input  logic       sw_bus_drop,
    input  logic       sw_clr_err,
    output logic [3:0] role_state,
    output logic       vbus_drive,
    output logic       host_en,
    output logic       periph_en,
    output logic       default_a
);
    role_state_e state_q;
    role_in_t    sig;
    logic        conn_flag, req_clr, err_take;
    logic        bus_req, bus_drop, clr_err, timeout;

    otg_req_latch u_req (
        .clk(clk), .rst(rst),
        .sw_bus_req(sw_bus_req), .sw_bus_drop(sw_bus_drop), .sw_clr_err(sw_clr_err),
        .fsm_req_clr(req_clr), .fsm_err_take(err_take),
        .bus_req(bus_req), .bus_drop(bus_drop), .clr_err(clr_err)
    );

    otg_wait_timer #(.BCON_TICKS(BCON_TICKS)) u_timer (
        .clk(clk), .rst(rst),
        .active(state_q == ST_AWAIT_PEER), .tick(tick_10ms),
        .expired(timeout)
    );

    always_comb begin
        sig.id         = id_pin;
        sig.a_vbus_vld = a_vbus_vld;
        sig.a_sess_vld = a_sess_vld;
        sig.b_sess_vld = b_sess_vld;
        sig.srp_det    = srp_det;
        sig.connect    = conn_flag && !peer_absent;
        sig.bus_req    = bus_req;
        sig.bus_drop   = bus_drop;
        sig.clr_err    = clr_err;
        sig.timeout    = timeout;
    end

    otg_role_fsm u_fsm (
        .clk(clk), .rst(rst), .sig(sig),
        .state_q(state_q), .vbus_drive(vbus_drive), .host_en(host_en),
        .periph_en(periph_en), .default_a(default_a), .conn_flag(conn_flag),
        .req_clr(req_clr), .err_take(err_take)
    );

    assign role_state = state_q;
endmodule

// File: tb/tb_otg_role_ctrl.sv
module tb_otg_role_ctrl;
    localparam int LIMIT = 2000;
    localparam int S_RST = 0, S_DIDLE = 1, S_DACT = 2, S_HIDLE = 3, S_RAMP = 4,
                   S_AWAIT = 5, S_HOSTING = 6, S_DRAIN = 7, S_FAULT = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic tick_10ms = 0, id_pin = 1, a_vbus_vld = 0, a_sess_vld = 0, b_sess_vld = 0;
    logic srp_det = 0, peer_absent = 0, sw_bus_req = 0, sw_bus_drop = 0, sw_clr_err = 0;
    logic [3:0] role_state;
    logic vbus_drive, host_en, periph_en, default_a;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    otg_role_ctrl #(.BCON_TICKS(LIMIT)) dut (
        .clk(clk), .rst(rst), .tick_10ms(tick_10ms), .id_pin(id_pin),
        .a_vbus_vld(a_vbus_vld), .a_sess_vld(a_sess_vld), .b_sess_vld(b_sess_vld),
        .srp_det(srp_det), .peer_absent(peer_absent), .sw_bus_req(sw_bus_req),
        .sw_bus_drop(sw_bus_drop), .sw_clr_err(sw_clr_err), .role_state(role_state),
        .vbus_drive(vbus_drive), .host_en(host_en), .periph_en(periph_en),
        .default_a(default_a)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_st(input string rq, input int exp);
        chk(rq, "role_state", int'(role_state), exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();  sw_bus_req = 1;  wait_n(1); sw_bus_req = 0;  endtask
    task automatic pulse_drop(); sw_bus_drop = 1; wait_n(1); sw_bus_drop = 0; endtask
    task automatic pulse_clr();  sw_clr_err = 1;  wait_n(1); sw_clr_err = 0;  endtask

    task automatic do_reset(input logic id_v, input logic vbus_v, input logic absent_v);
        @(negedge clk);
        rst = 1; tick_10ms = 0; a_sess_vld = 0; b_sess_vld = 0; srp_det = 0;
        sw_bus_req = 0; sw_bus_drop = 0; sw_clr_err = 0;
        id_pin = id_v; a_vbus_vld = vbus_v; peer_absent = absent_v;
        wait_n(3);
        chk_st("R1", S_RST);
        chk("R1", "outputs in reset", int'({vbus_drive, host_en, periph_en, default_a}), 0);
        rst = 0;
        wait_n(1);
    endtask

    task automatic t_dev_side();
        do_reset(1, 0, 0);
        chk_st("R1", S_DIDLE);
        b_sess_vld = 1; wait_n(1);
        chk_st("R4", S_DACT);  chk("R4", "periph_en", periph_en, 1);
        b_sess_vld = 0; wait_n(1);
        chk_st("R4", S_DIDLE); chk("R4", "periph_en", periph_en, 0);
        b_sess_vld = 1; wait_n(1);
        chk_st("R2", S_DACT);
        id_pin = 0; wait_n(1);
        chk_st("R3", S_DIDLE); chk("R4", "periph_en", periph_en, 0);
        wait_n(1);
        chk_st("R4", S_HIDLE); chk("R13", "default_a", default_a, 1);
    endtask

    task automatic t_host_path();
        do_reset(0, 0, 0);
        chk_st("R1", S_HIDLE);
        srp_det = 1; wait_n(1);
        chk_st("R5", S_RAMP); chk("R5", "vbus_drive", vbus_drive, 1);
        srp_det = 0; wait_n(3);
        chk_st("R6", S_RAMP);
        a_vbus_vld = 1; wait_n(1);
        chk_st("R6", S_AWAIT); chk("R6", "host_en", host_en, 1);
        wait_n(1);
        chk_st("R6", S_HOSTING);
        pulse_drop();
        chk_st("R12", S_HOSTING);
        wait_n(1);
        chk_st("R9", S_AWAIT); chk("R6", "host_en kept", host_en, 1);
        wait_n(1);
        chk_st("R7", S_DRAIN); chk("R10", "vbus_drive", vbus_drive, 0);
        wait_n(2);
        chk_st("R10", S_DRAIN);
        a_sess_vld = 1; wait_n(1);
        chk_st("R10", S_HIDLE); chk("R10", "host_en", host_en, 0);
        wait_n(3);
        chk_st("R12", S_HIDLE);
        a_sess_vld = 0;
        pulse_req();
        chk_st("R12", S_HIDLE);
        wait_n(1); chk_st("R12", S_RAMP);
        wait_n(1); chk_st("R6", S_AWAIT);
        wait_n(1); chk_st("R6", S_HOSTING);
        a_vbus_vld = 0; wait_n(1);
        chk_st("R9", S_FAULT); chk("R11", "vbus_drive held", vbus_drive, 1);
        wait_n(3);
        chk_st("R11", S_FAULT);
        pulse_clr();
        wait_n(1);
        chk_st("R11", S_DRAIN); chk("R10", "vbus_drive", vbus_drive, 0);
        wait_n(1); chk_st("R10", S_HIDLE);
        wait_n(1); chk_st("R5", S_RAMP);
        a_vbus_vld = 1;
        wait_n(1); chk_st("R6", S_AWAIT);
        wait_n(1); chk_st("R6", S_HOSTING);
        a_vbus_vld = 0; wait_n(1);
        chk_st("R9", S_FAULT);
        wait_n(2);
        chk_st("R11", S_FAULT);
    endtask

    task automatic t_await_priority();
        do_reset(0, 1, 1);
        pulse_req();
        wait_n(1); chk_st("R5", S_RAMP);
        wait_n(1); chk_st("R6", S_AWAIT);
        wait_n(5); chk_st("R8", S_AWAIT);
        id_pin = 1; a_vbus_vld = 0; wait_n(1);
        chk_st("R7", S_DRAIN);
        wait_n(1); chk_st("R10", S_HIDLE); chk("R13", "default_a", default_a, 1);
        wait_n(1); chk_st("R5", S_DIDLE);  chk("R13", "default_a", default_a, 0);
        id_pin = 0; wait_n(1);
        chk_st("R4", S_HIDLE);
        wait_n(3);
        chk_st("R7", S_HIDLE);
    endtask

    task automatic t_await_vbus_loss();
        do_reset(0, 1, 1);
        pulse_req();
        wait_n(2); chk_st("R6", S_AWAIT);
        a_vbus_vld = 0; wait_n(1);
        chk_st("R7", S_FAULT);
    endtask

    task automatic t_host_reentry();
        do_reset(0, 1, 0);
        pulse_req();
        wait_n(3); chk_st("R6", S_HOSTING);
        peer_absent = 1; wait_n(1);
        chk_st("R9", S_AWAIT); chk("R6", "host_en", host_en, 1);
        wait_n(2); chk_st("R9", S_AWAIT);
        peer_absent = 0; wait_n(1);
        chk_st("R6", S_HOSTING);
    endtask

    task automatic t_timeout();
        do_reset(0, 1, 1);
        pulse_req();
        wait_n(2); chk_st("R6", S_AWAIT);
        wait_n(40); chk_st("R8", S_AWAIT);
        tick_10ms = 1;
        wait_n(LIMIT);
        chk_st("R8", S_AWAIT); chk("R8", "vbus_drive", vbus_drive, 1);
        wait_n(1);
        chk_st("R8", S_DRAIN); chk("R7", "vbus_drive", vbus_drive, 0);
        tick_10ms = 0;
        wait_n(3); chk_st("R10", S_DRAIN);
        a_sess_vld = 1; wait_n(1);
        chk_st("R10", S_HIDLE);
        a_sess_vld = 0;
        wait_n(3); chk_st("R7", S_HIDLE);
        sw_bus_req = 1; sw_bus_drop = 1; wait_n(1);
        sw_bus_req = 0; sw_bus_drop = 0;
        wait_n(3); chk_st("R12", S_HIDLE);
        pulse_req();
        wait_n(1); chk_st("R12", S_RAMP);
    endtask

    initial begin
        t_dev_side();
        t_host_path();
        t_await_priority();
        t_await_vbus_loss();
        t_host_reentry();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule